// File: doc/BRIEF.md
# Streaming Mask Bit-Scan Unit

This unit carries out vector mask instructions that walk a mask source in element order. It covers seven operations: population count, find-first-set, set-before-first, set-including-first, set-only-first, iota (a running prefix count) and element index. The mask source arrives as a stream of fixed-width chunks under a valid/ready handshake. The unit handles one chunk at a time. Between chunks it keeps a sticky "first found" flag, a running count, the index of the first hit and the base index of the current chunk. From these it produces a scalar result, a stream of output mask chunks, or a stream of full-width elements, one element per beat.

An instruction is accepted through the start handshake while the unit is idle. The instruction carries an opcode, the vector length `vl` and the unmasked flag `vm`. When `vm` is 0, each chunk comes with a predicate chunk. Elements whose predicate bit is 0 are inactive. Every scan ignores bits at or beyond `vl`.

Top module: `mask_scan_unit`

## Requirements
- R1: Opcode encodings on `op_i` are 0 population count, 1 find-first, 2 set-before-first, 3 set-including-first, 4 set-only-first, 5 iota and 6 element index. An instruction is taken only when `start_valid_i` and `start_ready_o` are both high, and `start_ready_o` is high only when the unit is idle. Code 7 is dropped: the unit stays idle and raises no output valid.
- R2: Population count returns, on the scalar channel, the number of active set mask bits at indices below `vl`.
- R3: Find-first returns the index of the lowest active set mask bit below `vl`. When there is no such bit it returns all ones.
- R4: Set-before-first sets output bit i when element i is active and no active set bit exists at any index up to and including i.
- R5: Set-including-first sets output bit i when element i is active and no active set bit exists at any index below i.
- R6: Set-only-first sets exactly the output bit of the lowest active set bit, and no other bit. This holds across chunk boundaries.
- R7: Iota emits `vl` elements. Element i equals the number of active set mask bits at indices below i, and the count carries between chunks.
- R8: Element index emits the values 0 to `vl`-1 in order and consumes no source chunk.
- R9: Bits at or beyond `vl` are ignored. Output mask bits at or beyond `vl` are 0. A mask operation emits ceil(`vl`/CHUNK_W) chunks. With `vl` = 0, population count returns 0, find-first returns all ones, and the vector operations produce no output.
- R10: With `vm_i` = 0, an element whose predicate bit is 0 does not count and cannot be the first hit, and its output mask bit is 0.
- R11: Each result stays valid and unchanged until it is accepted. In a mask operation, a source chunk is accepted only in the cycle its output chunk is accepted.
- R12: At most one result channel is valid at a time, and none is valid while the unit is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_valid_i | input | 1 | Instruction offered |
| start_ready_o | output | 1 | Unit idle, instruction taken |
| op_i | input | 3 | Opcode |
| vl_i | input | VL_W | Vector length in elements |
| vm_i | input | 1 | 1 = unmasked, 0 = use predicate |
| src_valid_i | input | 1 | Source chunk valid |
| src_ready_o | output | 1 | Source chunk accepted |
| src_bits_i | input | CHUNK_W | Mask source chunk, bit k is element base+k |
| pred_bits_i | input | CHUNK_W | Predicate chunk aligned with the source chunk |
| scalar_valid_o | output | 1 | Scalar result valid |
| scalar_ready_i | input | 1 | Scalar result taken |
| scalar_o | output | SCALAR_W | Count or first index |
| mask_valid_o | output | 1 | Output mask chunk valid |
| mask_ready_i | input | 1 | Output mask chunk taken |
| mask_o | output | CHUNK_W | Output mask chunk |
| elem_valid_o | output | 1 | Output element valid |
| elem_ready_i | input | 1 | Output element taken |
| elem_o | output | ELEM_W | Iota or index element |

## Verification
The bench targets a first set bit in a later chunk, or exactly on a chunk boundary. If the found flag is not carried between chunks, set-only-first emits a second 1 and find-first reports a later index. It targets set bits above a `vl` that is not chunk-aligned: a design that leaks them gives counts and first indices that are too large, or nonzero tail mask bits. Runs with `vm_i` = 0 show whether an inactive element is wrongly counted or wrongly chosen as the first hit. Heavy back-pressure together with `vl` = 0 and the unused opcode exposes dropped or duplicated beats, a missing scalar on a zero-length count, and an unused opcode that leaves the unit stuck busy.

// File: rtl/msu_pkg.sv
package msu_pkg;
  typedef enum logic [2:0] {
    OP_POPC  = 3'd0,
    OP_FIRST = 3'd1,
    OP_SBF   = 3'd2,
    OP_SIF   = 3'd3,
    OP_SOF   = 3'd4,
    OP_IOTA  = 3'd5,
    OP_INDEX = 3'd6,
    OP_NONE  = 3'd7
  } scan_op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_ELEM,
    ST_SCALAR
  } scan_st_e;
endpackage

// File: rtl/msu_vl_window.sv
module msu_vl_window #(
  parameter int unsigned CHUNK_W = 64,
  parameter int unsigned IDX_W   = 9
) (
  input  logic [IDX_W-1:0]   base_i,
  input  logic [IDX_W-1:0]   vl_i,
  output logic [CHUNK_W-1:0] win_o
);
  localparam int unsigned SUM_W = IDX_W + 1;

  for (genvar k = 0; k < CHUNK_W; k++) begin : g_win
    assign win_o[k] = ({1'b0, base_i} + SUM_W'(k)) < {1'b0, vl_i};
  end
endmodule

// File: rtl/msu_chunk_scan.sv
module msu_chunk_scan
  import msu_pkg::*;
#(
  parameter int unsigned CHUNK_W = 64,
  parameter int unsigned POS_W   = 6
) (
  input  scan_op_e           op_i,
  input  logic [CHUNK_W-1:0] eff_i,
  input  logic [CHUNK_W-1:0] act_i,
  input  logic               found_i,
  output logic [CHUNK_W-1:0] mask_o,
  output logic [POS_W:0]     pop_o,
  output logic               any_o,
  output logic [POS_W-1:0]   first_pos_o
);
  logic seen;

  always_comb begin
    seen        = found_i;
    pop_o       = '0;
    any_o       = 1'b0;
    first_pos_o = '0;
    mask_o      = '0;
    for (int k = 0; k < CHUNK_W; k++) begin
      if (op_i == OP_SBF)      mask_o[k] = act_i[k] & ~seen & ~eff_i[k];
      else if (op_i == OP_SIF) mask_o[k] = act_i[k] & ~seen;
      else if (op_i == OP_SOF) mask_o[k] = eff_i[k] & ~seen;
      if (eff_i[k] && !any_o) first_pos_o = POS_W'(k);
      any_o = any_o | eff_i[k];
      seen  = seen | eff_i[k];
      pop_o = pop_o + (POS_W+1)'(eff_i[k]);
    end
  end
endmodule

// File: rtl/mask_scan_unit.sv
module mask_scan_unit
  import msu_pkg::*;
#(
  parameter int unsigned CHUNK_W  = 64,
  parameter int unsigned VL_W     = 8,
  parameter int unsigned ELEM_W   = 16,
  parameter int unsigned SCALAR_W = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_valid_i,
  output logic                start_ready_o,
  input  logic [2:0]          op_i,
  input  logic [VL_W-1:0]     vl_i,
  input  logic                vm_i,
  input  logic                src_valid_i,
  output logic                src_ready_o,
  input  logic [CHUNK_W-1:0]  src_bits_i,
  input  logic [CHUNK_W-1:0]  pred_bits_i,
  output logic                scalar_valid_o,
  input  logic                scalar_ready_i,
  output logic [SCALAR_W-1:0] scalar_o,
  output logic                mask_valid_o,
  input  logic                mask_ready_i,
  output logic [CHUNK_W-1:0]  mask_o,
  output logic                elem_valid_o,
  input  logic                elem_ready_i,
  output logic [ELEM_W-1:0]   elem_o
);
  // CHUNK_W must be a power of two and no larger than 2**VL_W
  localparam int unsigned POS_W = $clog2(CHUNK_W);
  localparam int unsigned IDX_W = VL_W + 1;

  scan_st_e            st_q;
  scan_op_e            op_q;
  logic [VL_W-1:0]     vl_q;
  logic                vm_q;
  logic [IDX_W-1:0]    base_q;
  logic [POS_W-1:0]    pos_q;
  logic                found_q;
  logic [SCALAR_W-1:0] cnt_q;
  logic [SCALAR_W-1:0] first_q;
  logic [CHUNK_W-1:0]  hold_q;

  logic [CHUNK_W-1:0]  win, act, eff, scan_mask;
  logic [POS_W:0]      pop;
  logic                any_hit;
  logic [POS_W-1:0]    first_pos;
  logic [IDX_W-1:0]    vl_ext, base_nxt, elem_idx;
  logic                last_chunk, last_elem, chunk_end;
  logic                is_mask_op, is_scalar_op, src_fire;
  scan_op_e            op_in;

  assign vl_ext = {1'b0, vl_q};

  msu_vl_window #(.CHUNK_W(CHUNK_W), .IDX_W(IDX_W)) win_i (
    .base_i (base_q),
    .vl_i   (vl_ext),
    .win_o  (win)
  );

  assign act = win & (vm_q ? {CHUNK_W{1'b1}} : pred_bits_i);
  assign eff = src_bits_i & act;

  msu_chunk_scan #(.CHUNK_W(CHUNK_W), .POS_W(POS_W)) scan_i (
    .op_i        (op_q),
    .eff_i       (eff),
    .act_i       (act),
    .found_i     (found_q),
    .mask_o      (scan_mask),
    .pop_o       (pop),
    .any_o       (any_hit),
    .first_pos_o (first_pos)
  );

  assign op_in        = scan_op_e'(op_i);
  assign is_mask_op   = (op_q == OP_SBF) || (op_q == OP_SIF) || (op_q == OP_SOF);
  assign is_scalar_op = (op_q == OP_POPC) || (op_q == OP_FIRST);
  assign base_nxt     = base_q + IDX_W'(CHUNK_W);
  assign last_chunk   = base_nxt >= vl_ext;
  assign elem_idx     = base_q + IDX_W'(pos_q);
  assign last_elem    = (elem_idx + IDX_W'(1)) == vl_ext;
  assign chunk_end    = &pos_q;

  assign start_ready_o  = (st_q == ST_IDLE);
  assign src_ready_o    = (st_q == ST_RUN) && (is_mask_op ? mask_ready_i : 1'b1);
  assign src_fire       = src_valid_i && src_ready_o;
  assign mask_valid_o   = (st_q == ST_RUN) && is_mask_op && src_valid_i;
  assign mask_o         = scan_mask;
  assign scalar_valid_o = (st_q == ST_SCALAR);
  assign scalar_o       = (op_q == OP_FIRST) ? first_q : cnt_q;
  assign elem_valid_o   = (st_q == ST_ELEM);
  assign elem_o         = (op_q == OP_IOTA) ? ELEM_W'(cnt_q) : ELEM_W'(elem_idx);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      op_q    <= OP_POPC;
      vl_q    <= '0;
      vm_q    <= 1'b1;
      base_q  <= '0;
      pos_q   <= '0;
      found_q <= 1'b0;
      cnt_q   <= '0;
      first_q <= '1;
      hold_q  <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (start_valid_i && op_in != OP_NONE) begin
            op_q    <= op_in;
            vl_q    <= vl_i;
            vm_q    <= vm_i;
            base_q  <= '0;
            pos_q   <= '0;
            found_q <= 1'b0;
            cnt_q   <= '0;
            first_q <= '1;
            if (vl_i == '0)
              st_q <= (op_in == OP_POPC || op_in == OP_FIRST) ? ST_SCALAR : ST_IDLE;
            else
              st_q <= (op_in == OP_INDEX) ? ST_ELEM : ST_RUN;
          end
        end
        ST_RUN: begin
          if (src_fire) begin
            found_q <= found_q | any_hit;
            if (op_q == OP_POPC) cnt_q <= cnt_q + SCALAR_W'(pop);
            if (op_q == OP_FIRST && !found_q && any_hit)
              first_q <= SCALAR_W'(base_q) + SCALAR_W'(first_pos);
            if (op_q == OP_IOTA) begin
              hold_q <= eff;
              pos_q  <= '0;
              st_q   <= ST_ELEM;
            end else if (last_chunk) begin
              st_q <= is_scalar_op ? ST_SCALAR : ST_IDLE;
            end else begin
              base_q <= base_nxt;
            end
          end
        end
        ST_ELEM: begin
          if (elem_ready_i) begin
            if (op_q == OP_IOTA) cnt_q <= cnt_q + SCALAR_W'(hold_q[pos_q]);
            if (last_elem) begin
              st_q <= ST_IDLE;
            end else if (chunk_end) begin
              base_q <= base_nxt;
              pos_q  <= '0;
              st_q   <= (op_q == OP_IOTA) ? ST_RUN : ST_ELEM;
            end else begin
              pos_q <= pos_q + POS_W'(1);
            end
          end
        end
        ST_SCALAR: begin
          if (scalar_ready_i) st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/msu_checker.sv
module msu_checker #(
  parameter int unsigned ELEM_W   = 16,
  parameter int unsigned SCALAR_W = 32
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                start_ready_o,
  input logic                src_valid_i,
  input logic                src_ready_o,
  input logic                scalar_valid_o,
  input logic                scalar_ready_i,
  input logic [SCALAR_W-1:0] scalar_o,
  input logic                mask_valid_o,
  input logic                mask_ready_i,
  input logic                elem_valid_o,
  input logic                elem_ready_i,
  input logic [ELEM_W-1:0]   elem_o
);
  p_one_channel_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({scalar_valid_o, mask_valid_o, elem_valid_o}));

  p_idle_quiet_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_ready_o |-> !(scalar_valid_o || mask_valid_o || elem_valid_o));

  p_scalar_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scalar_valid_o && !scalar_ready_i |=> scalar_valid_o && $stable(scalar_o));

  p_elem_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    elem_valid_o && !elem_ready_i |=> elem_valid_o && $stable(elem_o));

  p_mask_backpressure_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_valid_o && !mask_ready_i |-> !src_ready_o);

  p_mask_from_src_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_valid_o |-> src_valid_i);
endmodule

bind mask_scan_unit msu_checker #(.ELEM_W(ELEM_W), .SCALAR_W(SCALAR_W)) chk_i (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .start_ready_o  (start_ready_o),
  .src_valid_i    (src_valid_i),
  .src_ready_o    (src_ready_o),
  .scalar_valid_o (scalar_valid_o),
  .scalar_ready_i (scalar_ready_i),
  .scalar_o       (scalar_o),
  .mask_valid_o   (mask_valid_o),
  .mask_ready_i   (mask_ready_i),
  .elem_valid_o   (elem_valid_o),
  .elem_ready_i   (elem_ready_i),
  .elem_o         (elem_o)
);

// File: tb/mask_scan_unit_tb_top.sv
`timescale 1ns/1ps
module mask_scan_unit_tb_top;
  localparam int CW = 64;
  localparam int VLW = 8;
  localparam int EW = 16;
  localparam int SW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_valid = 1'b0, start_ready;
  logic [2:0] op = '0;
  logic [VLW-1:0] vl = '0;
  logic vm = 1'b1;
  logic src_valid = 1'b0, src_ready;
  logic [CW-1:0] src_bits = '0, pred_bits = '0;
  logic scalar_valid, scalar_ready = 1'b0;
  logic [SW-1:0] scalar;
  logic mask_valid, mask_ready = 1'b0;
  logic [CW-1:0] mask;
  logic elem_valid, elem_ready = 1'b0;
  logic [EW-1:0] elem;

  always #2.5 clk = ~clk;

  mask_scan_unit #(.CHUNK_W(CW), .VL_W(VLW), .ELEM_W(EW), .SCALAR_W(SW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .start_valid_i(start_valid), .start_ready_o(start_ready),
    .op_i(op), .vl_i(vl), .vm_i(vm),
    .src_valid_i(src_valid), .src_ready_o(src_ready),
    .src_bits_i(src_bits), .pred_bits_i(pred_bits),
    .scalar_valid_o(scalar_valid), .scalar_ready_i(scalar_ready), .scalar_o(scalar),
    .mask_valid_o(mask_valid), .mask_ready_i(mask_ready), .mask_o(mask),
    .elem_valid_o(elem_valid), .elem_ready_i(elem_ready), .elem_o(elem)
  );

  int n_checks = 0;
  int n_fail = 0;
  bit [255:0] src_v, pred_v;
  logic [255:0] got_mask;
  int got_elem[256];
  int n_mask, n_elem, n_scalar;
  logic [31:0] got_scalar;

  task automatic check(input bit ok, input string req, input logic [255:0] act_v,
                       input logic [255:0] exp_v);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act_v, exp_v);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  task automatic do_op(input int op_v, input int vl_v, input bit vm_v, input int stall,
                       input string req);
    int ci = 0;
    int cyc = 0;
    int cnt = 0;
    logic [31:0] first = '1;
    bit seen = 0;
    logic [255:0] exp_mask = '0;
    int exp_elem[256];
    bit ok;
    got_mask = '0; n_mask = 0; n_elem = 0; n_scalar = 0; got_scalar = '0;
    @(negedge clk);
    start_valid = 1'b1; op = 3'(op_v); vl = VLW'(vl_v); vm = vm_v;
    forever begin
      @(negedge clk);
      start_valid = 1'b0;
      src_valid    = (($urandom % 100) >= stall);
      src_bits     = (ci < 4) ? src_v[ci*CW +: CW] : '0;
      pred_bits    = (ci < 4) ? pred_v[ci*CW +: CW] : '0;
      mask_ready   = (($urandom % 100) >= stall);
      elem_ready   = (($urandom % 100) >= stall);
      scalar_ready = (($urandom % 100) >= stall);
      #1;
      if (start_ready) break;
      if (mask_valid && mask_ready) begin
        if (n_mask < 4) got_mask[n_mask*CW +: CW] = mask;
        n_mask++;
      end
      if (elem_valid && elem_ready) begin
        if (n_elem < 256) got_elem[n_elem] = int'(elem);
        n_elem++;
      end
      if (scalar_valid && scalar_ready) begin
        got_scalar = scalar;
        n_scalar++;
      end
      if (src_valid && src_ready) ci++;
      cyc++;
      if (cyc > 4000) begin
        check(1'b0, {req, " hung"}, 256'(cyc), 0);
        break;
      end
    end
    src_valid = 1'b0; mask_ready = 1'b0; elem_ready = 1'b0; scalar_ready = 1'b0;
    for (int i = 0; i < vl_v; i++) begin
      bit a = vm_v | pred_v[i];
      bit e = a & src_v[i];
      exp_elem[i] = (op_v == 5) ? cnt : i;
      if (op_v == 2) exp_mask[i] = a & !seen & !e;
      if (op_v == 3) exp_mask[i] = a & !seen;
      if (op_v == 4) exp_mask[i] = e & !seen;
      if (e && !seen) first = 32'(i);
      seen = seen | e;
      cnt += int'(e);
    end
    case (op_v)
      0: check(n_scalar == 1 && got_scalar == 32'(cnt), req, 256'(got_scalar), 256'(cnt));
      1: check(n_scalar == 1 && got_scalar == first, req, 256'(got_scalar), 256'(first));
      2, 3, 4: begin
        // R9: chunk count and zero tail
        check(n_mask == (vl_v + CW - 1) / CW, "R9", 256'(n_mask), 256'((vl_v + CW - 1) / CW));
        check(got_mask == exp_mask, req, got_mask, exp_mask);
      end
      default: begin
        check(n_elem == vl_v, "R9", 256'(n_elem), 256'(vl_v));
        ok = 1'b1;
        for (int i = 0; i < vl_v && i < n_elem; i++) begin
          if (got_elem[i] != exp_elem[i] && ok) begin
            ok = 1'b0;
            check(1'b0, req, 256'(got_elem[i]), 256'(exp_elem[i]));
          end
        end
        if (ok) check(1'b1, req, 0, 0);
      end
    endcase
  endtask

  function automatic string op_req(input int o);
    case (o)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3: return "R5";
      4: return "R6";
      5: return "R7";
      default: return "R8";
    endcase
  endfunction

  initial begin
    #(200000 * 5);
    check(1'b0, "watchdog", 0, 0);
    finish_run();
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R12: idle after reset, no result valid
    check(start_ready && !scalar_valid && !mask_valid && !elem_valid, "R12",
          256'({start_ready, scalar_valid, mask_valid, elem_valid}), 256'(4'b1000));

    // R1: unused opcode is dropped
    @(negedge clk);
    start_valid = 1'b1; op = 3'd7; vl = 8'd10;
    @(negedge clk);
    start_valid = 1'b0;
    #1;
    check(start_ready && !scalar_valid && !mask_valid && !elem_valid, "R1",
          256'({start_ready, scalar_valid, mask_valid, elem_valid}), 256'(4'b1000));

    // R3: no set bit gives all ones; R9: hit beyond vl ignored
    src_v = '0; pred_v = '1;
    do_op(1, 200, 1'b1, 0, "R3");
    src_v = '0; src_v[150] = 1'b1;
    do_op(1, 150, 1'b1, 0, "R9");
    do_op(0, 150, 1'b1, 0, "R9");
    do_op(1, 151, 1'b1, 20, "R3");
    // R6: first hit exactly on chunk boundary, later hits in further chunks
    src_v = '0; src_v[64] = 1'b1; src_v[65] = 1'b1; src_v[200] = 1'b1;
    for (int o = 2; o <= 4; o++) do_op(o, 255, 1'b1, 10, op_req(o));
    do_op(5, 130, 1'b1, 0, "R7");
    // R9: zero length
    do_op(0, 0, 1'b1, 0, "R9");
    do_op(1, 0, 1'b1, 0, "R9");
    do_op(4, 0, 1'b1, 0, "R9");
    do_op(6, 0, 1'b1, 0, "R9");
    // R10: predicate hides the first hit
    src_v = '0; src_v[3] = 1'b1; src_v[70] = 1'b1;
    pred_v = '1; pred_v[3] = 1'b0;
    do_op(1, 100, 1'b0, 0, "R10");
    do_op(3, 100, 1'b0, 0, "R10");
    do_op(8'd6, 70, 1'b1, 30, "R8");

    for (int t = 0; t < 60; t++) begin
      int o = $urandom % 7;
      int l = 1 + ($urandom % 255);
      bit m = $urandom % 2;
      int s = (t % 5 == 0) ? 70 : ($urandom % 40);
      int dens = $urandom % 3;
      for (int w = 0; w < 8; w++) begin
        logic [31:0] r = $urandom;
        for (int d = 0; d < dens; d++) r = r & $urandom;
        src_v[w*32 +: 32] = r;
        pred_v[w*32 +: 32] = $urandom;
      end
      if (t % 9 == 0) l = CW * (1 + $urandom % 3);
      do_op(o, l, m, s, (s > 50) ? "R11" : (!m ? "R10" : op_req(o)));
    end
    finish_run();
  end
endmodule